// File: doc/BRIEF.md
# Extended-Address AND Execution Unit

This unit carries out one four-byte logical AND instruction over a flat 12-bit register space. The instruction bytes are taken one per cycle from a byte-wide fetch port. The first byte selects one of two forms. In the register form, the source and destination addresses are both 12-bit fields packed across the three bytes that follow. In the immediate form, an 8-bit literal is followed by a 12-bit destination. Any other first byte is rejected.

An operand whose upper eight address bits equal EEh is a shorthand for a working register. The low nibble then picks the register, and the register pointer supplies the page and group bits. After decoding, the unit reads its operands through a single-port memory and writes the result back to the destination. It then updates the zero, sign and overflow flags and pulses a completion output.

Top module: `xand_unit`

## Requirements
- R1: First byte 58h selects the register form: byte 2 holds source address bits [11:4], byte 3 holds {source bits [3:0], destination bits [11:8]}, and byte 4 holds destination bits [7:0].
- R2: First byte 59h selects the immediate form: byte 2 is the literal, byte 3 holds {ignored nibble, destination bits [11:8]}, and byte 4 holds destination bits [7:0].
- R3: A decoded operand address whose bits [11:4] are EEh is replaced by {ptr[3:0], ptr[7:4], addr[3:0]}, where ptr is the register pointer.
- R4: In the register form, the memory bus shows a source read, a destination read and a destination write in three consecutive cycles. The first of these cycles follows the acceptance of byte 4, and read data returns one cycle after the read.
- R5: In the immediate form there is no source read: a destination read is followed directly by the destination write.
- R6: The value written to the destination is the bitwise AND of the destination's old value and the source value.
- R7: Flags change only in the done cycle. Zero is set when the result is 00h, sign equals result bit 7, and overflow is cleared. Otherwise the flags keep their value.
- R8: Done is high for exactly one cycle, the cycle right after the write.
- R9: Any other first byte raises illegal for the single cycle after it is accepted. That instruction makes no memory access and changes no flag, and the unit goes back to waiting for a first byte.
- R10: The register pointer is captured when byte 4 is accepted. Later changes to it do not affect the addresses of that instruction.
- R11: The fetch ready output is high only while the unit is waiting for instruction bytes. Bytes offered while it is busy are ignored.
- R12: After reset the unit is ready, all flags are clear, and done, illegal and both memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| reg_ptr | input | 8 | Register pointer for working-register shorthand |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Unsupported first byte seen |

## Verification
The hardest case to reach from the ports is a working-register operand whose pointer changes while the instruction is still in flight. If the pointer were sampled at the wrong time, the wrong page would be read or written. The stimulus holds a chosen pointer value while byte 4 is offered. It then scrambles the pointer, and keeps offering junk bytes, through every later cycle of that instruction. The per-cycle model predicts the bus addresses from the captured pointer, so any late sampling shows up as an address mismatch. Random instructions that put EEh in the source, the destination or both, including source and destination aliasing the same location, extend this beyond the directed cases.

// File: rtl/xand_unit.sv
module xand_unit #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [7:0] OP_REG = 8'h58,
  parameter logic [7:0] OP_IMM = 8'h59,
  parameter logic [7:0] ESC_HI = 8'hEE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  input  logic [7:0]    reg_ptr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_v,
  output logic          done,
  output logic          illegal
);

  typedef enum logic [2:0] {ST_IDLE, ST_B1, ST_B2, ST_B3, ST_RDS, ST_RDD, ST_WR} st_t;

  st_t st;
  logic          imm_form;
  logic [7:0]    byte1, byte2;
  logic [AW-1:0] src_a, dst_a;
  logic [DW-1:0] opnd;

  function automatic logic [AW-1:0] resolve(input logic [AW-1:0] a, input logic [7:0] p);
    if (a[AW-1:4] == ESC_HI) return {p[3:0], p[7:4], a[3:0]};
    return a;
  endfunction

  wire take = in_valid && in_ready;

  assign in_ready  = (st == ST_IDLE) || (st == ST_B1) || (st == ST_B2) || (st == ST_B3);
  assign mem_rd    = (st == ST_RDS) || (st == ST_RDD);
  assign mem_wr    = (st == ST_WR);
  assign mem_addr  = (st == ST_RDS) ? src_a : dst_a;
  assign mem_wdata = opnd & mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      imm_form <= 1'b0;
      byte1    <= '0;
      byte2    <= '0;
      src_a    <= '0;
      dst_a    <= '0;
      opnd     <= '0;
      flag_z   <= 1'b0;
      flag_s   <= 1'b0;
      flag_v   <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          if (in_byte == OP_REG || in_byte == OP_IMM) begin
            imm_form <= (in_byte == OP_IMM);
            st       <= ST_B1;
          end else begin
            illegal <= 1'b1;
          end
        end
        ST_B1: if (take) begin
          byte1 <= in_byte;
          st    <= ST_B2;
        end
        ST_B2: if (take) begin
          byte2 <= in_byte;
          st    <= ST_B3;
        end
        ST_B3: if (take) begin
          src_a <= resolve({byte1, byte2[7:4]}, reg_ptr);
          dst_a <= resolve({byte2[3:0], in_byte}, reg_ptr);
          opnd  <= byte1;
          st    <= imm_form ? ST_RDD : ST_RDS;
        end
        ST_RDS: st <= ST_RDD;
        ST_RDD: begin
          if (!imm_form) opnd <= mem_rdata;
          st <= ST_WR;
        end
        ST_WR: begin
          flag_z <= (mem_wdata == '0);
          flag_s <= mem_wdata[DW-1];
          flag_v <= 1'b0;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_write_after_dst_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && $past(mem_addr) == mem_addr));

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({flag_z, flag_s, flag_v}));

  a_r7_flags_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ($past(mem_wdata) == '0) && flag_s == $past(mem_wdata[DW-1]) && !flag_v));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr));

  a_r9_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_rd && !mem_wr && !done && in_ready && $past(in_valid && in_ready)));

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !in_ready);

endmodule

// File: tb/tb_xand_unit.sv
module tb_xand_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready;
  logic [7:0]  reg_ptr = '0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        flag_z, flag_s, flag_v, done, illegal;

  xand_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .reg_ptr(reg_ptr), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flag_z(flag_z), .flag_s(flag_s),
    .flag_v(flag_v), .done(done), .illegal(illegal)
  );

  logic [7:0] ram [4096];
  logic [7:0] shadow [4096];

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0;
  int n_fail = 0;
  logic        e_rdy = 1'b1, e_rd = 1'b0, e_wr = 1'b0, e_done = 1'b0, e_ill = 1'b0;
  logic        e_z = 1'b0, e_s = 1'b0, e_v = 1'b0;
  logic [11:0] e_addr = '0;
  logic [7:0]  e_wd = '0;
  string       t_addr = "R12";
  string       t_acc = "R12";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      chk("R11", "in_ready", int'(in_ready), int'(e_rdy));
      chk(t_acc, "mem_rd", int'(mem_rd), int'(e_rd));
      chk(t_acc, "mem_wr", int'(mem_wr), int'(e_wr));
      if (e_rd || e_wr) chk(t_addr, "mem_addr", int'(mem_addr), int'(e_addr));
      if (e_wr) chk("R6", "mem_wdata", int'(mem_wdata), int'(e_wd));
      chk("R8", "done", int'(done), int'(e_done));
      chk("R9", "illegal", int'(illegal), int'(e_ill));
      chk("R7", "flag_z", int'(flag_z), int'(e_z));
      chk("R7", "flag_s", int'(flag_s), int'(e_s));
      chk("R7", "flag_v", int'(flag_v), int'(e_v));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_cyc(input logic rdy, input logic rd, input logic wr,
                            input logic [11:0] a, input logic [7:0] wd,
                            input logic dn, input logic il);
    e_rdy = rdy; e_rd = rd; e_wr = wr; e_addr = a; e_wd = wd; e_done = dn; e_ill = il;
  endtask

  function automatic logic [11:0] map_addr(input logic [11:0] a, input logic [7:0] p);
    if (a[11:4] == 8'hEE) return {p[3:0], p[7:4], a[3:0]};
    return a;
  endfunction

  task automatic poke(input logic [11:0] a, input logic [7:0] v);
    ram[a] = v;
    shadow[a] = v;
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [7:0] b3, input logic [7:0] rp);
    logic [11:0] sa, da;
    logic [7:0]  sv, dv, r;
    logic        rr, esc;
    if (op != 8'h58 && op != 8'h59) begin
      t_acc = "R9";
      in_valid = 1'b1; in_byte = op;
      expect_cyc(1, 0, 0, '0, '0, 0, 1);
      tick();
      in_valid = 1'b0;
      expect_cyc(1, 0, 0, '0, '0, 0, 0);
      tick();
      return;
    end
    rr  = (op == 8'h58);
    sa  = map_addr({b1, b2[7:4]}, rp);
    da  = map_addr({b2[3:0], b3}, rp);
    esc = (rr && b1 == 8'hEE) || ({b2[3:0], b3[7:4]} == 8'hEE);
    sv  = rr ? shadow[sa] : b1;
    dv  = shadow[da];
    r   = sv & dv;
    shadow[da] = r;
    t_acc  = rr ? "R4" : "R5";
    t_addr = rr ? "R1" : "R2";
    in_valid = 1'b1; in_byte = op;
    expect_cyc(1, 0, 0, '0, '0, 0, 0);
    tick();
    in_byte = b1; tick();
    in_byte = b2; tick();
    in_byte = b3; reg_ptr = rp;
    if (esc) t_addr = "R3";
    expect_cyc(0, 1, 0, rr ? sa : da, '0, 0, 0);
    tick();
    in_byte = 8'($urandom); reg_ptr = ~rp ^ 8'($urandom);
    if (esc) t_addr = "R10";
    if (rr) begin
      expect_cyc(0, 1, 0, da, '0, 0, 0);
      tick();
      in_byte = 8'($urandom); reg_ptr = 8'($urandom);
    end
    expect_cyc(0, 0, 1, da, r, 0, 0);
    tick();
    e_z = (r == 8'h00); e_s = r[7]; e_v = 1'b0;
    expect_cyc(1, 0, 0, '0, '0, 1, 0);
    tick();
    in_valid = 1'b0;
    expect_cyc(1, 0, 0, '0, '0, 0, 0);
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion (R8)");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i] = 8'(i * 37 + (i >> 4) + 5);
      shadow[i] = ram[i];
    end
    repeat (3) tick();
    chk("R12", "reset in_ready", int'(in_ready), 1);
    chk("R12", "reset strobes", int'(mem_rd | mem_wr | done | illegal), 0);
    chk("R12", "reset flags", int'({flag_z, flag_s, flag_v}), 0);
    rst_n = 1'b1;
    tick(); tick();

    poke(12'h93A, 8'hF5); poke(12'h142, 8'h0A);
    run(8'h58, 8'h14, 8'h29, 8'h3A, 8'h00);
    poke(12'hD7A, 8'hF7);
    run(8'h59, 8'hF0, 8'h0D, 8'h7A, 8'h00);
    run(8'h57, 8'h00, 8'h00, 8'h00, 8'h00);
    run(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00);
    poke(12'hA35, 8'hCE); poke(12'h1C0, 8'hB7);
    run(8'h58, 8'hEE, 8'h51, 8'hC0, 8'h3A);
    poke(12'h2C7, 8'h9D);
    run(8'h59, 8'h3C, 8'h0E, 8'hE7, 8'hC2);
    poke(12'hF52, 8'h6B); poke(12'hF59, 8'hFE);
    run(8'h58, 8'hEE, 8'h2E, 8'hE9, 8'h5F);
    poke(12'h123, 8'h81);
    run(8'h58, 8'h12, 8'h31, 8'h23, 8'h00);
    run(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] op, b1, b2, b3;
      int sel;
      sel = $urandom_range(0, 19);
      op  = (sel < 9) ? 8'h58 : (sel < 18) ? 8'h59 : 8'($urandom);
      b1  = ($urandom_range(0, 3) == 0) ? 8'hEE : 8'($urandom);
      b2  = 8'($urandom);
      b3  = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        b2[3:0] = 4'hE;
        b3[7:4] = 4'hE;
      end
      run(op, b1, b2, b3, 8'($urandom));
    end

    for (int i = 0; i < 4096; i++) begin
      if (ram[i] != shadow[i]) begin
        n_fail++;
        $display("FAIL R6 memory %0h: actual %0h expected %0h", i, ram[i], shadow[i]);
      end
    end
    n_chk++;
    finish_run();
  end
endmodule